// File: doc/BRIEF.md
# Dual-Stage Supervisory Reset Sequencer

This block drives two active-low reset lines for a processor subsystem. It has two causes for a reset. One is a synchronous power-good flag from an external supply comparator. The other is a single-cycle timeout strobe from a watchdog. Either cause pulls both reset lines low on the same clock edge.

Once the cause has cleared, the primary line (for the processor) is released after a short hold. The auxiliary line (for surrounding circuitry) is released after a longer hold, so the processor is running before its peripherals leave reset. When the primary line releases, the block emits a one-cycle rearm strobe that restarts the watchdog.

Hold times are given in milliseconds. A prescaler derives a millisecond tick from the clock frequency parameter, and the prescaler restarts whenever a hold interval starts, so every release lands on an exact clock count.

Top module: `rst_seq_top`

## Requirements
- R1: Whenever a reset cause is sampled, both `sys_rst_n` and `aux_rst_n` are low after that same clock edge. `sys_rst_n` never falls while `aux_rst_n` is high.
- R2: While `pwr_good` is sampled low, both outputs are low from the following edge onward, with no timer involved.
- R3: After `pwr_good` is first sampled high again, `sys_rst_n` rises on the HOLD1_MS*CLKS_PER_MS-th clock edge after that sampling edge.
- R4: `aux_rst_n` rises on the HOLD2_MS*CLKS_PER_MS-th clock edge after the same starting edge (HOLD2_MS > HOLD1_MS).
- R5: A `wdt_timeout` sampled high while `sys_rst_n` is high pulls both outputs low. The same release delays as in R3 and R4 then apply, counted from that sampling edge. This includes the interval in which only `aux_rst_n` is still low.
- R6: `wdt_rearm` is high for exactly one cycle, in the cycle in which `sys_rst_n` has just risen, whatever caused the reset. It is never high otherwise.
- R7: If `pwr_good` drops during either hold interval, both outputs go low again and both holds restart from the edge at which power-good is next sampled high.
- R8: A `wdt_timeout` sampled while `sys_rst_n` is low has no effect on either release time.
- R9: During synchronous reset (`rst_n` low), both outputs and `wdt_rearm` are low. With `pwr_good` high, `sys_rst_n` rises on the HOLD1_MS*CLKS_PER_MS-th edge after the last edge that sampled `rst_n` low, and `aux_rst_n` rises on the HOLD2_MS*CLKS_PER_MS-th.
- R10: `aux_rst_n` is never high while `sys_rst_n` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Synchronous supply-good flag, high when the supply is in tolerance |
| wdt_timeout | input | 1 | Watchdog expiry strobe, active high |
| sys_rst_n | output | 1 | Primary (processor) reset, active low |
| aux_rst_n | output | 1 | Auxiliary (peripheral) reset, active low, released last |
| wdt_rearm | output | 1 | One-cycle strobe that restarts the watchdog |

## Verification
The assertions check on every cycle the relationships that involve no elapsed time:
- the two lines fall together and are released in order;
- a power-good loss forces both lines low on the next edge;
- the rearm strobe matches the primary release exactly;
- the prescaler and millisecond counters stay in range.

Only the bench scenarios can show exact release counts. It checks them after power return, after reset, and after watchdog expiry in both the fully released and the half-released state. It also sweeps every power-drop offset across both hold intervals and every watchdog strobe offset inside the primary hold, to show the restart and ignore rules.

// File: rtl/rst_seq_pkg.sv
// Package: shared types for the reset sequencer.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package rst_seq_pkg;

    // Sequencer phases: waiting on power, primary hold, auxiliary hold, released.
    typedef enum logic [1:0] {
        PH_FAULT = 2'd0,
        PH_HOLD1 = 2'd1,
        PH_HOLD2 = 2'd2,
        PH_RUN   = 2'd3
    } seq_phase_t;

endpackage

// File: rtl/rst_seq_ms_prescaler.sv
// Module: rst_seq_ms_prescaler
// Divides the clock down to a one-cycle millisecond tick.
// Assumes: clr restarts the division so that the first tick comes exactly
// CLKS_PER_MS cycles after clr is released; no tick is produced while clr is high.
module rst_seq_ms_prescaler #(
    parameter int CLKS_PER_MS = 50_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);

    generate
        if (CLKS_PER_MS <= 1) begin : g_bypass
            // Every non-cleared cycle is a tick when no division is needed.
            assign tick = !clr;
        end else begin : g_divide
            localparam int PW = $clog2(CLKS_PER_MS);
            localparam logic [PW-1:0] LAST = PW'(CLKS_PER_MS - 1);

            logic [PW-1:0] div_q;

            assign tick = !clr && (div_q == LAST);

            // Advance the divider, wrapping at the end of each millisecond.
            always_ff @(posedge clk) begin
                if (!rst_n || clr) begin
                    div_q <= '0;
                end else if (div_q == LAST) begin
                    div_q <= '0;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end

            // R3
            div_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
                div_q <= LAST);
        end
    endgenerate

endmodule

// File: rtl/rst_seq_hold_counter.sv
// Module: rst_seq_hold_counter
// Counts millisecond ticks since the start of a hold and flags the tick that
// ends the primary hold and the tick that ends the auxiliary hold.
// Assumes: 1 <= HOLD1_MS < HOLD2_MS; clr zeroes the count.
module rst_seq_hold_counter #(
    parameter int HOLD1_MS = 50,
    parameter int HOLD2_MS = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic tick,
    output logic end1,
    output logic end2
);

    localparam int CW = $clog2(HOLD2_MS + 1);
    localparam logic [CW-1:0] LIM1 = CW'(HOLD1_MS - 1);
    localparam logic [CW-1:0] LIM2 = CW'(HOLD2_MS - 1);
    localparam logic [CW-1:0] CAP  = CW'(HOLD2_MS);

    logic [CW-1:0] ms_q;

    assign end1 = tick && (ms_q == LIM1);
    assign end2 = tick && (ms_q == LIM2);

    // Count elapsed milliseconds, saturating once the longest hold has passed.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ms_q <= '0;
        end else if (tick && ms_q != CAP) begin
            ms_q <= ms_q + 1'b1;
        end
    end

    // R4
    ms_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ms_q <= CAP);

    // R4
    end_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(end1 && end2));

endmodule

// File: rtl/rst_seq_ctrl.sv
// Module: rst_seq_ctrl
// Phase controller: decides when the two reset lines fall and release and
// when the watchdog rearm strobe fires.
// Assumes: end1/end2 come from a counter that clr_hold restarts; wdt_timeout
// is a synchronous strobe; pwr_good is already synchronised.
module rst_seq_ctrl
    import rst_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic wdt_timeout,
    input  logic end1,
    input  logic end2,
    output logic clr_hold,
    output logic sys_rst_n,
    output logic aux_rst_n,
    output logic wdt_rearm
);

    seq_phase_t phase_q;

    // Hold timing restarts outside the hold phases and on any re-trigger.
    always_comb begin
        clr_hold = !pwr_good
                || (phase_q == PH_FAULT)
                || (phase_q == PH_RUN)
                || (phase_q == PH_HOLD2 && wdt_timeout);
    end

    // Step the phase and drive the registered reset lines and rearm strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q   <= PH_HOLD1;
            sys_rst_n <= 1'b0;
            aux_rst_n <= 1'b0;
            wdt_rearm <= 1'b0;
        end else begin
            wdt_rearm <= 1'b0;
            if (!pwr_good) begin
                phase_q   <= PH_FAULT;
                sys_rst_n <= 1'b0;
                aux_rst_n <= 1'b0;
            end else begin
                case (phase_q)
                    PH_FAULT: phase_q <= PH_HOLD1;
                    PH_HOLD1: begin
                        if (end1) begin
                            phase_q   <= PH_HOLD2;
                            sys_rst_n <= 1'b1;
                            wdt_rearm <= 1'b1;
                        end
                    end
                    PH_HOLD2: begin
                        if (wdt_timeout) begin
                            phase_q   <= PH_HOLD1;
                            sys_rst_n <= 1'b0;
                            aux_rst_n <= 1'b0;
                        end else if (end2) begin
                            phase_q   <= PH_RUN;
                            aux_rst_n <= 1'b1;
                        end
                    end
                    default: begin
                        if (wdt_timeout) begin
                            phase_q   <= PH_HOLD1;
                            sys_rst_n <= 1'b0;
                            aux_rst_n <= 1'b0;
                        end
                    end
                endcase
            end
        end
    end

    // R1
    fall_together_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_n) |-> !aux_rst_n);

    // R2
    pwr_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (!sys_rst_n && !aux_rst_n));

    // R6
    rearm_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> wdt_rearm);

    // R6
    rearm_only_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rearm |-> $rose(sys_rst_n));

    // R10
    release_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        aux_rst_n |-> sys_rst_n);

    // R8
    wdt_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_rst_n && pwr_good && !end1) |=> !sys_rst_n);

endmodule

// File: rtl/rst_seq_top.sv
// Module: rst_seq_top
// Two-stage supervisory reset sequencer: power loss or watchdog expiry
// asserts both reset lines. The primary line releases HOLD1_MS after the
// cause clears and the auxiliary line releases HOLD2_MS after it, and a
// rearm strobe accompanies the primary release.
// Assumes: CLK_HZ is a multiple of 1 kHz; 1 <= HOLD1_MS < HOLD2_MS.
module rst_seq_top #(
    parameter int CLK_HZ   = 50_000_000,
    parameter int HOLD1_MS = 50,
    parameter int HOLD2_MS = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic wdt_timeout,
    output logic sys_rst_n,
    output logic aux_rst_n,
    output logic wdt_rearm
);

    localparam int CLKS_PER_MS = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;

    logic clr_hold;
    logic ms_tick;
    logic end1;
    logic end2;

    rst_seq_ms_prescaler #(
        .CLKS_PER_MS(CLKS_PER_MS)
    ) u_prescaler (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr_hold),
        .tick (ms_tick)
    );

    rst_seq_hold_counter #(
        .HOLD1_MS(HOLD1_MS),
        .HOLD2_MS(HOLD2_MS)
    ) u_hold (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr_hold),
        .tick (ms_tick),
        .end1 (end1),
        .end2 (end2)
    );

    rst_seq_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_good   (pwr_good),
        .wdt_timeout(wdt_timeout),
        .end1       (end1),
        .end2       (end2),
        .clr_hold   (clr_hold),
        .sys_rst_n  (sys_rst_n),
        .aux_rst_n  (aux_rst_n),
        .wdt_rearm  (wdt_rearm)
    );

endmodule

// File: tb/test_rst_seq_top.sv
// Bench for rst_seq_top with a small configuration: 4 clocks per ms,
// holds of 5 ms and 7 ms. Release edges are computed from the parameters.
module test_rst_seq_top;

    localparam int CLK_HZ = 4000;
    localparam int H1     = 5;
    localparam int H2     = 7;
    localparam int CPM    = CLK_HZ / 1000;
    localparam int H1C    = H1 * CPM;
    localparam int H2C    = H2 * CPM;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b1;
    logic wdt_timeout = 1'b0;
    logic sys_rst_n;
    logic aux_rst_n;
    logic wdt_rearm;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    rst_seq_top #(
        .CLK_HZ  (CLK_HZ),
        .HOLD1_MS(H1),
        .HOLD2_MS(H2)
    ) i_rst_seq_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_good   (pwr_good),
        .wdt_timeout(wdt_timeout),
        .sys_rst_n  (sys_rst_n),
        .aux_rst_n  (aux_rst_n),
        .wdt_rearm  (wdt_rearm)
    );

    // Record one check, and report it when it does not hold.
    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Sample from a negedge at count start. Find the edge counts at which
    // each line rises, and check that the rearm strobe appears once, at the first.
    task automatic measure(input int start, input int e1, input int e2, input string req1);
        int n = start;
        int t1 = -1;
        int t2 = -1;
        int pulses = 0;
        int pulse_at = -1;
        while (n < start + 200) begin
            if (sys_rst_n && t1 < 0) t1 = n;
            if (aux_rst_n && t2 < 0) t2 = n;
            if (wdt_rearm) begin
                pulses++;
                pulse_at = n;
            end
            if (t2 >= 0 && n > t2 + 1) break;
            @(negedge clk);
            n++;
        end
        chk(t1 == e1, req1, t1, e1);
        chk(t2 == e2, "R4 aux release", t2, e2);
        chk(pulses == 1 && pulse_at == t1, "R6 rearm", pulse_at, t1);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                failures++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
                $finish;
            end
        end
    end

    initial begin
        // R9: reset state, then release timing as if power had just returned.
        repeat (3) @(negedge clk);
        chk(!sys_rst_n && !aux_rst_n && !wdt_rearm, "R9 reset state",
            {sys_rst_n, aux_rst_n, wdt_rearm}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        measure(1, H1C, H2C, "R9 sys release after reset");

        // R2: outputs stay low for as long as power-good is low.
        pwr_good = 1'b0;
        @(negedge clk);
        chk(!sys_rst_n && !aux_rst_n, "R1 both low on power loss",
            {sys_rst_n, aux_rst_n}, 0);
        begin
            int bad = 0;
            for (int i = 0; i < 40; i++) begin
                @(negedge clk);
                if (sys_rst_n || aux_rst_n || wdt_rearm) bad++;
            end
            chk(bad == 0, "R2 held low", bad, 0);
        end
        // R3: release counted from power return.
        pwr_good = 1'b1;
        @(negedge clk);
        measure(1, H1C + 1, H2C + 1, "R3 sys release after power");

        // R5: watchdog expiry in the fully released state.
        wdt_timeout = 1'b1;
        @(negedge clk);
        wdt_timeout = 1'b0;
        chk(!sys_rst_n && !aux_rst_n, "R5 both low on timeout",
            {sys_rst_n, aux_rst_n}, 0);
        measure(1, H1C + 1, H2C + 1, "R5 sys release after timeout");

        // R5: watchdog expiry while only the auxiliary line is held.
        pwr_good = 1'b0;
        @(negedge clk);
        pwr_good = 1'b1;
        repeat (H1C + 2) @(negedge clk);
        chk(sys_rst_n && !aux_rst_n, "R5 half-released state",
            {sys_rst_n, aux_rst_n}, 2);
        wdt_timeout = 1'b1;
        @(negedge clk);
        wdt_timeout = 1'b0;
        chk(!sys_rst_n && !aux_rst_n, "R1 both low on timeout in aux hold",
            {sys_rst_n, aux_rst_n}, 0);
        measure(1, H1C + 1, H2C + 1, "R5 sys release after aux-hold timeout");

        // R7: power drop at every offset across both hold intervals.
        for (int d = 1; d <= H2C + 2; d++) begin
            pwr_good = 1'b0;
            @(negedge clk);
            pwr_good = 1'b1;
            repeat (d) @(negedge clk);
            pwr_good = 1'b0;
            @(negedge clk);
            chk(!sys_rst_n && !aux_rst_n, "R7 re-assert on drop",
                {sys_rst_n, aux_rst_n}, 0);
            pwr_good = 1'b1;
            @(negedge clk);
            measure(1, H1C + 1, H2C + 1, "R7 restart after drop");
        end

        // R8: a timeout strobe anywhere inside the primary hold changes nothing.
        for (int k = 0; k < H1C; k++) begin
            pwr_good = 1'b0;
            @(negedge clk);
            pwr_good = 1'b1;
            repeat (k) @(negedge clk);
            wdt_timeout = 1'b1;
            @(negedge clk);
            wdt_timeout = 1'b0;
            measure(k + 1, H1C + 1, H2C + 1, "R8 timeout ignored in hold");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule